// File: doc/BRIEF.md
# Command Executor with Configuration Register File

This block sits behind an I2C target that has already dealt with bus signalling and address matching. The target passes it one strobe per received byte, one pulse per frame start that also carries the direction bit, one pulse on STOP, and one pulse each time the next read byte is wanted. The block decodes each command byte and keeps four 8-bit configuration registers. It prepares the bytes for the next read frame and sends single-cycle control pulses to the conversion engine: filter reset and conversion start. It also raises a power-down level for that engine.

Read commands (register read, result read) arrive in a write frame. The reply goes out in the next read frame, which normally opens with a repeated START. A result reply can begin with a conversion counter byte. Two configuration fields can append either a CRC-16 (polynomial 1021h, seed FFFFh, MSB first) or a bitwise-inverted copy of every payload byte. Register writes may follow one another in the same frame without a STOP. Each register write resets the filter, and it restarts the conversion when one is running.

Top module: `cmd_exec`

## Requirements
- R1: A command byte is decoded with its don't-care bits ignored: 0000011x reset, 0000100x start/sync, 0000001x power-down, 0001xxxx result read, 0010rrxx register read, 0100rrxx register write, where rr = bits 3:2. Any other byte is accepted and has no effect on registers, pulses or the pending reply.
- R2: Every command acts in the clock cycle after its byte strobe. filt_rst_o and conv_start_o are high only in the cycle that follows a strobed byte.
- R3: Start/sync pulses conv_start_o and filt_rst_o together and clears power-down, whether or not the engine is busy.
- R4: Power-down keeps every register. pwrdn_o rises only in a cycle after conv_busy_i was sampled low, so it waits for a running conversion to end. Start/sync or reset clears it.
- R5: After a register-write command, the next byte of the same frame is written to register rr. The byte after that is decoded as a new command, so any number of writes can chain in one frame. cfg_o = {reg3, reg2, reg1, reg0}.
- R6: Each register write pulses filt_rst_o. It also pulses conv_start_o when conv_busy_i is high in the cycle of the data strobe.
- R7: A register read returns register rr as the first byte of the next read frame.
- R8: A result read captures the latest result when the command is latched. The next read frame returns the MSB and then the LSB, even if newer results arrive in between.
- R9: When reg2 bit 6 is set, a result reply starts with a counter byte. The counter counts accepted results modulo 256.
- R10: When reg2 bits 5:4 = 10, two CRC-16 bytes (high byte first) follow the payload. The CRC uses polynomial 1021h and seed FFFFh, is computed MSB first, and covers every payload byte including the counter byte.
- R11: When reg2 bits 5:4 = 01, the bitwise inverse of each payload byte follows the payload, in the same order. The value 11 adds nothing.
- R12: A read frame with no pending reply, and every byte past the end of a reply, reads FFh. A reply is used up by the first read frame that follows it.
- R13: The reset command sets every register, the latest result and the counter to zero, drops any pending reply, clears power-down and pulses filt_rst_o.
- R14: A STOP or a new frame start discards a register write that is still waiting for its data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Pulse on START or repeated START addressed to this device |
| frame_rd_i | input | 1 | Direction bit of the frame, valid with frame_start_i (1 = read) |
| frame_stop_i | input | 1 | Pulse on STOP |
| rx_valid_i | input | 1 | Pulse when a write-frame byte is latched |
| rx_byte_i | input | 8 | Received byte |
| tx_next_i | input | 1 | Advance to the next read byte |
| tx_byte_o | output | 8 | Byte to send in the current read slot |
| res_valid_i | input | 1 | A new conversion result is available |
| res_data_i | input | 16 | Conversion result |
| conv_busy_i | input | 1 | A conversion is in progress |
| cfg_o | output | 32 | Configuration registers, reg0 in the low byte |
| filt_rst_o | output | 1 | Filter reset pulse |
| conv_start_o | output | 1 | Conversion start pulse |
| pwrdn_o | output | 1 | Power-down request level |

## Verification
The bench drives opcodes that set their don't-care bits, and bytes that are not commands. A decoder that compares too many bits would miss the first kind; one that compares too few would act on the second. It breaks a register write with a STOP and then sends a start/sync. A design that keeps the stale write state would store that command byte as register data. It feeds a new result after a result read has been latched, which exposes a design that samples the result when the read frame opens. It also checks the CRC and inverted-copy replies, with and without the counter byte, against a separately computed reference. This catches wrong seeds, wrong byte order and coverage that leaves out the counter byte. Power-down is requested while the engine is busy, so a design that powers down at once is caught.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_RESET, OP_START, OP_PDOWN, OP_RDATA, OP_RREG, OP_WREG
  } op_e;

  localparam int OPT_REG     = 2;
  localparam int CNT_EN_BIT  = 6;
  localparam int INTEG_LSB   = 4;

  localparam logic [1:0] INTEG_INV = 2'b01;
  localparam logic [1:0] INTEG_CRC = 2'b10;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction
endpackage

// File: rtl/cmdx_decode.sv
module cmdx_decode
  import cmdx_pkg::*;
(
  input  logic [7:0] byte_i,
  output op_e        op_o,
  output logic [1:0] addr_o
);
  always_comb begin
    addr_o = byte_i[3:2];
    casez (byte_i)
      8'b0000_011?: op_o = OP_RESET;
      8'b0000_100?: op_o = OP_START;
      8'b0000_001?: op_o = OP_PDOWN;
      8'b0001_????: op_o = OP_RDATA;
      8'b0010_????: op_o = OP_RREG;
      8'b0100_????: op_o = OP_WREG;
      default:      op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/cmdx_regfile.sv
module cmdx_regfile #(
  parameter int NREG = 4,
  parameter int RW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [RW-1:0]      wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [RW-1:0]      rdata_o,
  output logic [NREG*RW-1:0] flat_o
);
  logic [RW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[g] <= '0;
      else if (clr_i)                                 regs_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))             regs_q[g] <= wdata_i;
    end
    assign flat_o[g*RW +: RW] = regs_q[g];
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/cmdx_reply.sv
module cmdx_reply
  import cmdx_pkg::*;
#(
  parameter int RES_W = 16,
  localparam int RB    = RES_W / 8,
  localparam int PLMAX = RB + 1,
  localparam int MAXB  = 2 * PLMAX,
  localparam int IW    = $clog2(MAXB + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drop_i,
  input  logic             load_i,
  input  logic             is_data_i,
  input  logic [7:0]       reg_byte_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [7:0]       cnt_i,
  input  logic             cnt_en_i,
  input  logic [1:0]       integ_i,
  input  logic             rd_start_i,
  input  logic             end_i,
  input  logic             next_i,
  output logic [7:0]       tx_o
);
  logic [7:0] pl [PLMAX];
  logic [7:0] nb [MAXB];
  int         plen, nlen;
  logic [15:0] crc;

  always_comb begin
    for (int k = 0; k < PLMAX; k++) pl[k] = 8'hFF;
    plen = 0;
    if (is_data_i) begin
      if (cnt_en_i) begin
        pl[0] = cnt_i;
        plen  = 1;
      end
      for (int k = 0; k < RB; k++) begin
        pl[plen] = res_i[RES_W-1-8*k -: 8];
        plen     = plen + 1;
      end
    end else begin
      pl[0] = reg_byte_i;
      plen  = 1;
    end
    crc = CRC_SEED;
    for (int k = 0; k < PLMAX; k++)
      if (k < plen) crc = crc16_byte(crc, pl[k]);
    for (int k = 0; k < MAXB; k++) nb[k] = 8'hFF;
    for (int k = 0; k < PLMAX; k++) nb[k] = pl[k];
    nlen = plen;
    if (integ_i == INTEG_INV) begin
      for (int k = 0; k < PLMAX; k++)
        if (k < plen) nb[plen+k] = ~pl[k];
      nlen = 2 * plen;
    end else if (integ_i == INTEG_CRC) begin
      nb[plen]   = crc[15:8];
      nb[plen+1] = crc[7:0];
      nlen       = plen + 2;
    end
  end

  logic [7:0]    buf_q [MAXB];
  logic [IW-1:0] len_q, idx_q;
  logic          pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAXB; k++) buf_q[k] <= 8'hFF;
      len_q  <= '0;
      idx_q  <= '0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (drop_i) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (load_i) begin
        for (int k = 0; k < MAXB; k++) buf_q[k] <= nb[k];
        len_q  <= IW'(nlen);
        pend_q <= 1'b1;
      end
      if (rd_start_i) begin
        act_q  <= pend_q;
        pend_q <= 1'b0;
        idx_q  <= '0;
      end else if (end_i) begin
        act_q <= 1'b0;
      end else if (next_i && act_q && idx_q < len_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign tx_o = (act_q && idx_q < len_q) ? buf_q[idx_q] : 8'hFF;
endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
  import cmdx_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int RES_W = 16,
  localparam int RW   = 8,
  localparam int AW   = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               frame_rd_i,
  input  logic               frame_stop_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  input  logic               tx_next_i,
  output logic [7:0]         tx_byte_o,
  input  logic               res_valid_i,
  input  logic [RES_W-1:0]   res_data_i,
  input  logic               conv_busy_i,
  output logic [NREG*RW-1:0] cfg_o,
  output logic               filt_rst_o,
  output logic               conv_start_o,
  output logic               pwrdn_o
);
  op_e        op;
  logic [1:0] op_addr;

  cmdx_decode u_dec (.byte_i(rx_byte_i), .op_o(op), .addr_o(op_addr));

  logic          wd_pend_q;
  logic [AW-1:0] wd_addr_q;
  logic          cmd_fire, data_fire, do_reset;

  assign cmd_fire  = rx_valid_i && !wd_pend_q;
  assign data_fire = rx_valid_i && wd_pend_q;
  assign do_reset  = cmd_fire && op == OP_RESET;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_pend_q <= 1'b0;
      wd_addr_q <= '0;
    end else if (frame_start_i || frame_stop_i || data_fire) begin
      wd_pend_q <= 1'b0;
    end else if (cmd_fire && op == OP_WREG) begin
      wd_pend_q <= 1'b1;
      wd_addr_q <= AW'(op_addr);
    end
  end

  logic [RW-1:0] rd_byte;

  cmdx_regfile #(.NREG(NREG), .RW(RW)) u_rf (
    .clk_i, .rst_ni,
    .clr_i  (do_reset),
    .we_i   (data_fire),
    .waddr_i(wd_addr_q),
    .wdata_i(rx_byte_i),
    .raddr_i(AW'(op_addr)),
    .rdata_o(rd_byte),
    .flat_o (cfg_o)
  );

  logic [RES_W-1:0] res_q;
  logic [7:0]       cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      cnt_q <= '0;
    end else if (do_reset) begin
      res_q <= '0;
      cnt_q <= '0;
    end else if (res_valid_i) begin
      res_q <= res_data_i;
      cnt_q <= cnt_q + 8'd1;
    end
  end

  logic [7:0] opt_reg;
  assign opt_reg = cfg_o[OPT_REG*RW +: RW];

  cmdx_reply #(.RES_W(RES_W)) u_rep (
    .clk_i, .rst_ni,
    .drop_i    (do_reset),
    .load_i    (cmd_fire && (op == OP_RDATA || op == OP_RREG)),
    .is_data_i (op == OP_RDATA),
    .reg_byte_i(rd_byte),
    .res_i     (res_q),
    .cnt_i     (cnt_q),
    .cnt_en_i  (opt_reg[CNT_EN_BIT]),
    .integ_i   (opt_reg[INTEG_LSB +: 2]),
    .rd_start_i(frame_start_i && frame_rd_i),
    .end_i     (frame_stop_i || (frame_start_i && !frame_rd_i)),
    .next_i    (tx_next_i),
    .tx_o      (tx_byte_o)
  );

  logic pd_req_q;
  logic wake;
  assign wake = cmd_fire && (op == OP_START || op == OP_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_rst_o   <= 1'b0;
      conv_start_o <= 1'b0;
      pd_req_q     <= 1'b0;
      pwrdn_o      <= 1'b0;
    end else begin
      filt_rst_o   <= (cmd_fire && (op == OP_RESET || op == OP_START)) || data_fire;
      conv_start_o <= (cmd_fire && op == OP_START) || (data_fire && conv_busy_i);
      if (wake) begin
        pd_req_q <= 1'b0;
        pwrdn_o  <= 1'b0;
      end else if (cmd_fire && op == OP_PDOWN) begin
        pd_req_q <= 1'b1;
      end else if (pd_req_q && !conv_busy_i) begin
        pd_req_q <= 1'b0;
        pwrdn_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_exec_chk.sv
module cmd_exec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_valid_i,
  input logic [7:0]  rx_byte_i,
  input logic        frame_stop_i,
  input logic        conv_busy_i,
  input logic [31:0] cfg_o,
  input logic        filt_rst_o,
  input logic        conv_start_o,
  input logic        pwrdn_o,
  input logic [7:0]  tx_byte_o,
  input logic        wd_pend
);
  assert_unknown_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !wd_pend && (rx_byte_i[7:4] > 4'h4 || rx_byte_i[7:4] == 4'h3)
    |=> !conv_start_o && !filt_rst_o && $stable(cfg_o));

  assert_no_stray_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !conv_start_o && !filt_rst_o);

  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !wd_pend && rx_byte_i[7:1] == 7'h04
    |=> conv_start_o && filt_rst_o && !pwrdn_o);

  assert_pd_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwrdn_o) |-> !$past(conv_busy_i));

  assert_cfg_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_i && wd_pend) && !(rx_valid_i && rx_byte_i[7:1] == 7'h03)
    |=> $stable(cfg_o));

  assert_wreg_filter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && wd_pend |=> filt_rst_o);

  assert_idle_ff_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stop_i |=> tx_byte_o == 8'hFF);
endmodule

bind cmd_exec cmd_exec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rx_byte_i   (rx_byte_i),
  .frame_stop_i(frame_stop_i),
  .conv_busy_i (conv_busy_i),
  .cfg_o       (cfg_o),
  .filt_rst_o  (filt_rst_o),
  .conv_start_o(conv_start_o),
  .pwrdn_o     (pwrdn_o),
  .tx_byte_o   (tx_byte_o),
  .wd_pend     (wd_pend_q)
);

// File: tb/sim_cmd_exec.sv
module sim_cmd_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 0, frame_rd = 0, frame_stop = 0;
  logic        rx_valid = 0, tx_next = 0, res_valid = 0, busy = 0;
  logic [7:0]  rx_byte = 0;
  logic [15:0] res_data = 0;
  logic [7:0]  tx_byte;
  logic [31:0] cfg;
  logic        filt_rst, conv_start, pwrdn;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_cnt = 0;

  always #4 clk = ~clk;

  cmd_exec u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .frame_start_i(frame_start), .frame_rd_i(frame_rd), .frame_stop_i(frame_stop),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_next_i(tx_next), .tx_byte_o(tx_byte),
    .res_valid_i(res_valid), .res_data_i(res_data), .conv_busy_i(busy),
    .cfg_o(cfg), .filt_rst_o(filt_rst), .conv_start_o(conv_start), .pwrdn_o(pwrdn)
  );

  // {addr, data} pairs written then read back
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd3, 8'hFF}, {2'd2, 8'h81},
    {2'd0, 8'h00}, {2'd1, 8'hC3}, {2'd3, 8'h5A}, {2'd2, 8'h0F}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [7:0] b [6], int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {b[i], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic tk(); @(negedge clk); endtask
  task automatic wstart(); frame_start = 1; frame_rd = 0; tk(); frame_start = 0; endtask
  task automatic rstart(); frame_start = 1; frame_rd = 1; tk(); frame_start = 0; frame_rd = 0; endtask
  task automatic stop(); frame_stop = 1; tk(); frame_stop = 0; endtask
  task automatic send(logic [7:0] b); rx_valid = 1; rx_byte = b; tk(); rx_valid = 0; endtask
  task automatic rbyte(output logic [7:0] b); b = tx_byte; tx_next = 1; tk(); tx_next = 0; endtask
  task automatic result(logic [15:0] v);
    res_valid = 1; res_data = v; tk(); res_valid = 0; exp_cnt++;
  endtask
  task automatic wreg(logic [1:0] a, logic [7:0] d);
    wstart(); send({4'h4, a, 2'b00}); send(d); stop();
  endtask
  task automatic cmd_then_read(logic [7:0] c, int n, output logic [7:0] got [6]);
    wstart(); send(c); rstart();
    for (int i = 0; i < 6; i++) got[i] = 8'hFF;
    for (int i = 0; i < n; i++) rbyte(got[i]);
    stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] g [6];
    logic [7:0] p [6];
    logic [7:0] b;
    logic [31:0] c0;
    logic [15:0] crc;
    repeat (3) tk();
    rst_n = 1'b1;
    tk();
    check("reset cfg", cfg, 32'h0);
    check("reset pwrdn", {31'd0, pwrdn}, 0);
    check("reset pulses", {30'd0, filt_rst, conv_start}, 0);
    check("R12 idle tx", {24'd0, tx_byte}, 32'hFF);

    // R5 R7: table of writes, each read back
    foreach (VEC[i]) begin
      logic [1:0] a = VEC[i][9:8];
      logic [7:0] d = VEC[i][7:0];
      wreg(a, d);
      check("R5 cfg byte", {24'd0, cfg[a*8 +: 8]}, {24'd0, d});
      cmd_then_read({4'h2, a, 2'b11}, 1, g);
      check("R7 readback", {24'd0, g[0]}, {24'd0, d});
    end

    // R13: reset via 07 (don't-care bit set)
    wstart(); send(8'h07); stop();
    check("R13 cfg cleared", cfg, 32'h0);
    exp_cnt = 0;

    // R1 R12: non-commands do nothing, no reply pending
    wreg(2'd1, 8'h77);
    c0 = cfg;
    wstart(); send(8'h80); check("R1 no pulse 80", {30'd0, filt_rst, conv_start}, 0);
    send(8'h35); check("R1 no pulse 35", {30'd0, filt_rst, conv_start}, 0);
    send(8'h00); rstart(); rbyte(b); stop();
    check("R1 cfg kept", cfg, c0);
    check("R12 no pending FF", {24'd0, b}, 32'hFF);

    // R3: start/sync 08 and 09, pulse one cycle
    wstart(); send(8'h09);
    check("R3 start pulse", {30'd0, filt_rst, conv_start}, 32'h3);
    tk();
    check("R2 pulse ends", {30'd0, filt_rst, conv_start}, 0);
    stop();

    // R4: power-down waits for busy to drop
    busy = 1;
    wstart(); send(8'h03); stop(); tk();
    check("R4 held while busy", {31'd0, pwrdn}, 0);
    busy = 0; tk();
    check("R4 power-down", {31'd0, pwrdn}, 1);
    check("R4 cfg kept", cfg, c0);
    wstart(); send(8'h08); stop();
    check("R3 wake", {31'd0, pwrdn}, 0);

    // R5 R6: chained writes, restart only when busy
    busy = 1;
    wstart(); send(8'h40); send(8'h11);
    check("R6 busy restart", {30'd0, filt_rst, conv_start}, 32'h3);
    busy = 0;
    send(8'h4C); send(8'h22);
    check("R6 idle filter only", {30'd0, filt_rst, conv_start}, 32'h2);
    stop();
    check("R5 chained", cfg, {8'h22, 8'h00, 8'h77, 8'h11});

    // R14: broken write, next frame byte is a command
    wstart(); send(8'h48); stop();
    wstart(); send(8'h08);
    check("R14 new command", {31'd0, conv_start}, 1);
    stop();
    check("R14 reg2 untouched", {24'd0, cfg[23:16]}, 0);

    // R8: capture at latch, later result ignored
    result(16'h1234);
    wstart(); send(8'h1F);
    result(16'hBEEF);
    rstart(); rbyte(g[0]); rbyte(g[1]); rbyte(g[2]); stop();
    check("R8 data", {16'd0, g[0], g[1]}, 32'h1234);
    check("R12 past end", {24'd0, g[2]}, 32'hFF);
    rstart(); rbyte(b); stop();
    check("R12 consumed", {24'd0, b}, 32'hFF);

    // R9: counter byte first
    wreg(2'd2, 8'h40);
    cmd_then_read(8'h10, 3, g);
    check("R9 counter", {24'd0, g[0]}, {24'd0, exp_cnt});
    check("R9 data", {16'd0, g[1], g[2]}, 32'hBEEF);

    // R10: CRC with counter
    wreg(2'd2, 8'h60);
    cmd_then_read(8'h10, 5, g);
    p = '{exp_cnt, 8'hBE, 8'hEF, 8'h00, 8'h00, 8'h00};
    crc = ref_crc(p, 3);
    check("R10 crc cnt", {g[3], g[4]}, {16'd0, crc});
    // R10: CRC without counter
    wreg(2'd2, 8'h20);
    result(16'h8001);
    cmd_then_read(8'h10, 5, g);
    p = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
    crc = ref_crc(p, 2);
    check("R10 crc", {g[0], g[1], g[2], g[3]}, {16'h8001, crc});
    check("R10 length", {24'd0, g[4]}, 32'hFF);
    // R10: register read with CRC
    cmd_then_read(8'h28, 3, g);
    p = '{8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    crc = ref_crc(p, 1);
    check("R10 reg crc", {8'd0, g[0], g[1], g[2]}, {8'd0, 8'h20, crc});

    // R11: inverted copy, with and without counter
    wreg(2'd2, 8'h10);
    cmd_then_read(8'h10, 5, g);
    check("R11 inv", {g[0], g[1], g[2], g[3]}, 32'h80017FFE);
    check("R11 length", {24'd0, g[4]}, 32'hFF);
    wreg(2'd2, 8'h50);
    cmd_then_read(8'h10, 6, g);
    check("R11 inv cnt", {g[0], g[3]}, {16'd0, exp_cnt, ~exp_cnt});
    check("R11 inv data", {g[4], g[5]}, 32'h7FFE);
    // R11: mode 11 adds nothing
    wreg(2'd2, 8'h30);
    cmd_then_read(8'h10, 3, g);
    check("R11 mode 11", {8'd0, g[0], g[1], g[2]}, 32'h0080_01FF);

    // R13: reset drops pending reply, clears counter/result
    wstart(); send(8'h10); send(8'h06);
    check("R13 filter pulse", {31'd0, filt_rst}, 1);
    rstart(); rbyte(b); stop();
    check("R13 reply dropped", {24'd0, b}, 32'hFF);
    wreg(2'd2, 8'h40);
    cmd_then_read(8'h10, 3, g);
    check("R13 counter result zero", {8'd0, g[0], g[1], g[2]}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule